// File: doc/BRIEF.md
# Context Probability State Unit

This block holds the adaptive probability state of every coding context of a binary arithmetic encoder. Each of the 19 contexts owns a state index into a fixed 47-state estimation table and a bit that records which decision value is currently the more probable symbol (MPS). The coder presents a context and a decision bit. One cycle later the unit returns the less-probable-symbol (LPS) probability Qe of that context's current state, the context's MPS bit, and a flag that marks the decision as an LPS event.

The coder then reports through an update strobe whether its interval arithmetic had to renormalise. The unit writes the context's state back using two separate rules. The index is rewritten only when renormalisation took place: it takes the next-on-MPS or next-on-LPS entry of the table. The MPS bit is inverted only on an LPS event in a state whose switch flag is set. The coder may look up the same context in the cycle in which that context's update is written back. In that case the freshly computed state is forwarded, so the coder never sees a stale value.

After reset an internal sequencer writes one context per clock with its starting index and an MPS of 0. The unit raises a ready output once all 19 contexts have been written. Interval arithmetic, renormalisation and byte output belong to the surrounding coder.

Top module: `ctxprob_unit`

## Requirements
- R1: After reset release, `ready_o` rises exactly 19 clock cycles later and then stays high. While `ready_o` is low, `res_vld_o` is 0 and lookups and updates are ignored.
- R2: After initialisation every context has MPS 0. Context 0 starts at state 4 (Qe 0x0521), context 17 at state 3 (Qe 0x0AC1), context 18 at state 46 (Qe 0x5601), and every other context at state 0 (Qe 0x5601).
- R3: A lookup (`look_vld` high while ready, context 0..18) sets `res_vld_o` at the next clock edge. `qe_o` and `mps_o` then show the Qe of the context's stored state and its stored MPS bit.
- R4: `lps_o` is 1 exactly when the looked-up decision bit differs from the returned MPS bit.
- R5: An update with `upd_renorm` high rewrites the index of the pending context. The new index is the next-on-MPS entry when `lps_o` is 0 and the next-on-LPS entry when `lps_o` is 1.
- R6: An update inverts the pending context's MPS bit only when `lps_o` is 1 and the current state's switch flag is set (states 0, 6 and 14). Otherwise the bit is unchanged.
- R7: An update with `upd_renorm` low leaves the index unchanged. An update strobe while `res_vld_o` is 0 has no effect on any stored state.
- R8: When a lookup of a context coincides with the update of that same pending context, the lookup returns the updated index and MPS bit.
- R9: An update changes only the state of the pending context. All other contexts keep their state.
- R10: An update with no lookup in the same cycle clears `res_vld_o` at that clock edge.
- R11: A lookup with a context number of 19 or above is ignored: the pending result and its outputs stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; starts the initialisation sequence |
| look_vld | input | 1 | Lookup strobe for a context/decision pair |
| look_ctx | input | 5 | Context number of the lookup |
| look_dec | input | 1 | Decision bit of the lookup |
| upd_vld | input | 1 | Update strobe for the pending context |
| upd_renorm | input | 1 | Set when the coder renormalised for the pending pair |
| ready_o | output | 1 | Initialisation complete |
| res_vld_o | output | 1 | A lookup result is pending |
| qe_o | output | 16 | LPS probability of the pending context's state |
| mps_o | output | 1 | MPS bit of the pending context |
| lps_o | output | 1 | Pending decision is an LPS event |

## Verification
A lookup result is due one clock edge after the lookup is accepted, and its effect on storage becomes visible to a lookup at the very edge of the update. The bench drives every stimulus at the falling edge and queues the expected result of each accepted lookup. A monitor samples 2 ns after the next rising edge and pops exactly one expected item there. Results that must not appear, such as a cleared valid flag or an output held after an ignored lookup, are sampled directly at the same point after the edge in question. The ready delay is counted edge by edge from reset release.

// File: rtl/ctxprob_pkg.sv
// Shared constants, types and start-state rule for the context
// probability state unit. Assumes the 47-state estimation table and
// 19 contexts of the MQ arithmetic coder.
package ctxprob_pkg;
    parameter int NUM_CTX   = 19;
    parameter int NUM_ST    = 47;
    parameter int QE_W      = 16;
    localparam int CTX_W    = $clog2(NUM_CTX);
    localparam int IDX_W    = $clog2(NUM_ST);

    // contexts that do not start in state 0, and their start states
    parameter int CTX_ZC0   = 0;
    parameter int CTX_RUN   = 17;
    parameter int CTX_UNI   = 18;
    parameter int START_ZC0 = 4;
    parameter int START_RUN = 3;
    parameter int START_UNI = 46;

    typedef logic [IDX_W-1:0] st_idx_t;
    typedef logic [CTX_W-1:0] ctx_t;

    typedef struct packed {
        logic [QE_W-1:0] qe;
        st_idx_t         nmps;
        st_idx_t         nlps;
        logic            sw;
    } prob_row_t;

    // starting state index of a context after initialisation
    function automatic st_idx_t start_index(ctx_t c);
        if (c == ctx_t'(CTX_ZC0)) return st_idx_t'(START_ZC0);
        if (c == ctx_t'(CTX_RUN)) return st_idx_t'(START_RUN);
        if (c == ctx_t'(CTX_UNI)) return st_idx_t'(START_UNI);
        return '0;
    endfunction
endpackage

// File: rtl/ctxprob_table.sv
// Read-only probability estimation table. Pure combinational lookup
// of Qe, next-on-MPS, next-on-LPS and switch flag by state index.
// Assumes idx < NUM_ST; other values return an all-zero row.
module ctxprob_table
    import ctxprob_pkg::*;
(
    input  st_idx_t   idx,
    output prob_row_t row
);
    function automatic prob_row_t mk(logic [15:0] q, int nm, int nl, logic s);
        prob_row_t r;
        r.qe   = QE_W'(q);
        r.nmps = st_idx_t'(nm);
        r.nlps = st_idx_t'(nl);
        r.sw   = s;
        return r;
    endfunction

    // table decode: one row per estimation state
    always_comb begin
        case (int'(idx))
            0:  row = mk(16'h5601,  1,  1, 1'b1);
            1:  row = mk(16'h3401,  2,  6, 1'b0);
            2:  row = mk(16'h1801,  3,  9, 1'b0);
            3:  row = mk(16'h0AC1,  4, 12, 1'b0);
            4:  row = mk(16'h0521,  5, 29, 1'b0);
            5:  row = mk(16'h0221, 38, 33, 1'b0);
            6:  row = mk(16'h5601,  7,  6, 1'b1);
            7:  row = mk(16'h5401,  8, 14, 1'b0);
            8:  row = mk(16'h4801,  9, 14, 1'b0);
            9:  row = mk(16'h3801, 10, 14, 1'b0);
            10: row = mk(16'h3001, 11, 17, 1'b0);
            11: row = mk(16'h2401, 12, 18, 1'b0);
            12: row = mk(16'h1C01, 13, 20, 1'b0);
            13: row = mk(16'h1601, 29, 21, 1'b0);
            14: row = mk(16'h5601, 15, 14, 1'b1);
            15: row = mk(16'h5401, 16, 14, 1'b0);
            16: row = mk(16'h5101, 17, 15, 1'b0);
            17: row = mk(16'h4801, 18, 16, 1'b0);
            18: row = mk(16'h3801, 19, 17, 1'b0);
            19: row = mk(16'h3401, 20, 18, 1'b0);
            20: row = mk(16'h3001, 21, 19, 1'b0);
            21: row = mk(16'h2801, 22, 19, 1'b0);
            22: row = mk(16'h2401, 23, 20, 1'b0);
            23: row = mk(16'h2201, 24, 21, 1'b0);
            24: row = mk(16'h1C01, 25, 22, 1'b0);
            25: row = mk(16'h1801, 26, 23, 1'b0);
            26: row = mk(16'h1601, 27, 24, 1'b0);
            27: row = mk(16'h1401, 28, 25, 1'b0);
            28: row = mk(16'h1201, 29, 26, 1'b0);
            29: row = mk(16'h1101, 30, 27, 1'b0);
            30: row = mk(16'h0AC1, 31, 28, 1'b0);
            31: row = mk(16'h09C1, 32, 29, 1'b0);
            32: row = mk(16'h08A1, 33, 30, 1'b0);
            33: row = mk(16'h0521, 34, 31, 1'b0);
            34: row = mk(16'h0441, 35, 32, 1'b0);
            35: row = mk(16'h02A1, 36, 33, 1'b0);
            36: row = mk(16'h0221, 37, 34, 1'b0);
            37: row = mk(16'h0141, 38, 35, 1'b0);
            38: row = mk(16'h0111, 39, 36, 1'b0);
            39: row = mk(16'h0085, 40, 37, 1'b0);
            40: row = mk(16'h0049, 41, 38, 1'b0);
            41: row = mk(16'h0025, 42, 39, 1'b0);
            42: row = mk(16'h0015, 43, 40, 1'b0);
            43: row = mk(16'h0009, 44, 41, 1'b0);
            44: row = mk(16'h0005, 45, 42, 1'b0);
            45: row = mk(16'h0001, 45, 43, 1'b0);
            46: row = mk(16'h5601, 46, 46, 1'b0);
            default: row = mk(16'h0000, 0, 0, 1'b0);
        endcase
    end
endmodule

// File: rtl/ctxprob_store.sv
// Per-context state storage: one index register and one MPS bit per
// context, a single write port for each, and an asynchronous read by
// context. Assumes the caller keeps rd_ctx and wr_ctx below NCTX.
module ctxprob_store
    import ctxprob_pkg::*;
#(
    parameter int NCTX = NUM_CTX
) (
    input  logic    clk,
    input  ctx_t    wr_ctx,
    input  logic    idx_we,
    input  st_idx_t idx_wd,
    input  logic    mps_we,
    input  logic    mps_wd,
    input  ctx_t    rd_ctx,
    output st_idx_t rd_idx,
    output logic    rd_mps
);
    st_idx_t idx_arr [NCTX];
    logic    mps_arr [NCTX];

    for (genvar g = 0; g < NCTX; g++) begin : g_ent
        localparam ctx_t ME = ctx_t'(g);
        st_idx_t ent_idx;
        logic    ent_mps;

        // entry write: take new data when the port addresses this entry
        always_ff @(posedge clk) begin
            if (idx_we && wr_ctx == ME) ent_idx <= idx_wd;
            if (mps_we && wr_ctx == ME) ent_mps <= mps_wd;
        end

        assign idx_arr[g] = ent_idx;
        assign mps_arr[g] = ent_mps;
    end

    assign rd_idx = idx_arr[rd_ctx];
    assign rd_mps = mps_arr[rd_ctx];
endmodule

// File: rtl/ctxprob_init.sv
// Initialisation sequencer: after reset, visits each context once per
// clock and then raises ready for good. Assumes reset restarts it.
module ctxprob_init
    import ctxprob_pkg::*;
#(
    parameter int NCTX = NUM_CTX
) (
    input  logic clk,
    input  logic rst_n,
    output logic wr_en,
    output ctx_t wr_ctx,
    output logic ready
);
    localparam ctx_t LAST = ctx_t'(NCTX - 1);
    ctx_t cnt;

    // sweep counter: one context per cycle until the last is written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (!ready) begin
            cnt <= cnt + ctx_t'(1);
            if (cnt == LAST) ready <= 1'b1;
        end
    end

    assign wr_en  = rst_n && !ready;
    assign wr_ctx = cnt;

    assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
endmodule

// File: rtl/ctxprob_unit.sv
// Context probability state unit. Accepts a context/decision lookup,
// returns Qe, MPS and LPS flag one cycle later, and writes back the
// context state on the coder's update strobe. Assumes at most one
// pending lookup; a same-context lookup at update time is forwarded.
module ctxprob_unit
    import ctxprob_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             look_vld,
    input  logic [CTX_W-1:0] look_ctx,
    input  logic             look_dec,
    input  logic             upd_vld,
    input  logic             upd_renorm,
    output logic             ready_o,
    output logic             res_vld_o,
    output logic [QE_W-1:0]  qe_o,
    output logic             mps_o,
    output logic             lps_o
);
    localparam ctx_t CTX_LAST = ctx_t'(NUM_CTX - 1);

    logic      init_wr;
    ctx_t      init_ctx;
    logic      ready;

    ctx_t      cur_ctx;
    logic      cur_dec;
    st_idx_t   cur_idx;
    logic      cur_mps;
    logic      res_vld_q;

    prob_row_t row;
    logic      lps;
    st_idx_t   nxt_idx;
    logic      nxt_mps;
    logic      look_fire;
    logic      upd_fire;
    logic      fwd;

    ctx_t      wr_ctx;
    logic      idx_we;
    st_idx_t   idx_wd;
    logic      mps_we;
    logic      mps_wd;
    st_idx_t   rd_idx;
    logic      rd_mps;

    ctxprob_init #(.NCTX(NUM_CTX)) u_init (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (init_wr),
        .wr_ctx (init_ctx),
        .ready  (ready)
    );

    ctxprob_table u_table (
        .idx (cur_idx),
        .row (row)
    );

    ctxprob_store #(.NCTX(NUM_CTX)) u_store (
        .clk    (clk),
        .wr_ctx (wr_ctx),
        .idx_we (idx_we),
        .idx_wd (idx_wd),
        .mps_we (mps_we),
        .mps_wd (mps_wd),
        .rd_ctx (look_ctx),
        .rd_idx (rd_idx),
        .rd_mps (rd_mps)
    );

    // event decode and next state of the pending context
    always_comb begin
        look_fire = ready && look_vld && (look_ctx <= CTX_LAST);
        upd_fire  = ready && upd_vld && res_vld_q;
        lps       = cur_dec ^ cur_mps;
        nxt_idx   = cur_idx;
        if (upd_renorm) nxt_idx = lps ? row.nlps : row.nmps;
        nxt_mps   = cur_mps ^ (lps & row.sw);
        fwd       = look_fire && upd_fire && (look_ctx == cur_ctx);
    end

    // write port select: sequencer during init, update write-back after
    always_comb begin
        if (init_wr) begin
            wr_ctx = init_ctx;
            idx_we = 1'b1;
            idx_wd = start_index(init_ctx);
            mps_we = 1'b1;
            mps_wd = 1'b0;
        end else begin
            wr_ctx = cur_ctx;
            idx_we = upd_fire && upd_renorm;
            idx_wd = nxt_idx;
            mps_we = upd_fire && lps && row.sw;
            mps_wd = ~cur_mps;
        end
    end

    // pending-pair register: capture a lookup, retire on update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ctx   <= '0;
            cur_dec   <= 1'b0;
            cur_idx   <= '0;
            cur_mps   <= 1'b0;
            res_vld_q <= 1'b0;
        end else if (look_fire) begin
            cur_ctx   <= look_ctx;
            cur_dec   <= look_dec;
            cur_idx   <= fwd ? nxt_idx : rd_idx;
            cur_mps   <= fwd ? nxt_mps : rd_mps;
            res_vld_q <= 1'b1;
        end else if (upd_fire) begin
            res_vld_q <= 1'b0;
        end
    end

    assign ready_o   = ready;
    assign res_vld_o = res_vld_q;
    assign qe_o      = row.qe;
    assign mps_o     = cur_mps;
    assign lps_o     = lps;

    assert_no_result_early_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> !res_vld_o);

    assert_result_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && look_vld && look_ctx <= CTX_LAST) |=> res_vld_o);

    assert_lps_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && look_vld && look_ctx <= CTX_LAST) |=> (lps_o == ($past(look_dec) ^ mps_o)));

    assert_result_retire_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && upd_vld && res_vld_o && !look_vld) |=> !res_vld_o);
endmodule

// File: tb/ctxprob_unit_test.sv
module ctxprob_unit_test;
    import ctxprob_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n, look_vld, look_dec, upd_vld, upd_renorm;
    logic [CTX_W-1:0] look_ctx;
    logic             ready_o, res_vld_o, mps_o, lps_o;
    logic [QE_W-1:0]  qe_o;

    ctxprob_unit uut (
        .clk(clk), .rst_n(rst_n), .look_vld(look_vld), .look_ctx(look_ctx),
        .look_dec(look_dec), .upd_vld(upd_vld), .upd_renorm(upd_renorm),
        .ready_o(ready_o), .res_vld_o(res_vld_o), .qe_o(qe_o),
        .mps_o(mps_o), .lps_o(lps_o)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // reference table: {qe, next-on-MPS, next-on-LPS}
    function automatic logic [31:0] ref_row(int s);
        case (s)
            0: return {16'h5601,8'd1,8'd1};    1: return {16'h3401,8'd2,8'd6};
            2: return {16'h1801,8'd3,8'd9};    3: return {16'h0AC1,8'd4,8'd12};
            4: return {16'h0521,8'd5,8'd29};   5: return {16'h0221,8'd38,8'd33};
            6: return {16'h5601,8'd7,8'd6};    7: return {16'h5401,8'd8,8'd14};
            8: return {16'h4801,8'd9,8'd14};   9: return {16'h3801,8'd10,8'd14};
            10: return {16'h3001,8'd11,8'd17}; 11: return {16'h2401,8'd12,8'd18};
            12: return {16'h1C01,8'd13,8'd20}; 13: return {16'h1601,8'd29,8'd21};
            14: return {16'h5601,8'd15,8'd14}; 15: return {16'h5401,8'd16,8'd14};
            16: return {16'h5101,8'd17,8'd15}; 17: return {16'h4801,8'd18,8'd16};
            18: return {16'h3801,8'd19,8'd17}; 19: return {16'h3401,8'd20,8'd18};
            20: return {16'h3001,8'd21,8'd19}; 21: return {16'h2801,8'd22,8'd19};
            22: return {16'h2401,8'd23,8'd20}; 23: return {16'h2201,8'd24,8'd21};
            24: return {16'h1C01,8'd25,8'd22}; 25: return {16'h1801,8'd26,8'd23};
            26: return {16'h1601,8'd27,8'd24}; 27: return {16'h1401,8'd28,8'd25};
            28: return {16'h1201,8'd29,8'd26}; 29: return {16'h1101,8'd30,8'd27};
            30: return {16'h0AC1,8'd31,8'd28}; 31: return {16'h09C1,8'd32,8'd29};
            32: return {16'h08A1,8'd33,8'd30}; 33: return {16'h0521,8'd34,8'd31};
            34: return {16'h0441,8'd35,8'd32}; 35: return {16'h02A1,8'd36,8'd33};
            36: return {16'h0221,8'd37,8'd34}; 37: return {16'h0141,8'd38,8'd35};
            38: return {16'h0111,8'd39,8'd36}; 39: return {16'h0085,8'd40,8'd37};
            40: return {16'h0049,8'd41,8'd38}; 41: return {16'h0025,8'd42,8'd39};
            42: return {16'h0015,8'd43,8'd40}; 43: return {16'h0009,8'd44,8'd41};
            44: return {16'h0005,8'd45,8'd42}; 45: return {16'h0001,8'd45,8'd43};
            default: return {16'h5601,8'd46,8'd46};
        endcase
    endfunction

    // reference state of the contexts and of the pending pair
    int m_idx [NUM_CTX];
    bit m_mps [NUM_CTX];
    bit c_vld;
    int c_ctx, c_idx;
    bit c_dec, c_mps;

    logic [17:0] exp_q [$];
    string       tag_q [$];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, reference update, expected push
    task automatic step(bit lv, int ctx, bit dec, bit uv, bit ren, string tag);
        logic [31:0] r;
        bit l;
        @(negedge clk);
        look_vld = lv; look_ctx = CTX_W'(ctx); look_dec = dec;
        upd_vld = uv; upd_renorm = ren;
        if (uv && c_vld) begin
            l = c_dec ^ c_mps;
            r = ref_row(c_idx);
            if (ren) m_idx[c_ctx] = l ? int'(r[7:0]) : int'(r[15:8]);
            if (l && (c_idx == 0 || c_idx == 6 || c_idx == 14)) m_mps[c_ctx] = ~c_mps;
        end
        if (lv && ctx < NUM_CTX) begin
            c_vld = 1; c_ctx = ctx; c_dec = dec;
            c_idx = m_idx[ctx]; c_mps = m_mps[ctx];
            r = ref_row(c_idx);
            exp_q.push_back({r[31:16], c_mps, dec ^ c_mps});
            tag_q.push_back(tag);
        end else if (uv && c_vld) begin
            c_vld = 0;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        look_vld = 0; upd_vld = 0; upd_renorm = 0;
    endtask

    // monitor: pop one expected result after each accepting edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [17:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {13'd0, res_vld_o, qe_o, mps_o, lps_o}, {13'd0, 1'b1, e});
            end
        end
    end

    initial begin
        #(1_000_000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int cyc;
        int unsigned lf;
        rst_n = 0; look_vld = 0; look_ctx = '0; look_dec = 0; upd_vld = 0; upd_renorm = 0;
        for (int i = 0; i < NUM_CTX; i++) begin
            m_mps[i] = 0;
            m_idx[i] = (i == 0) ? 4 : (i == 17) ? 3 : (i == 18) ? 46 : 0;
        end
        c_vld = 0;
        repeat (3) @(negedge clk);
        check("R1 reset ready", {31'd0, ready_o}, 32'd0);
        check("R1 reset res_vld", {31'd0, res_vld_o}, 32'd0);

        // R1: release reset with a lookup that must be ignored
        @(negedge clk);
        rst_n = 1; look_vld = 1; look_ctx = 5'd2;
        cyc = 0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #2;
            cyc++;
            if (ready_o) break;
        end
        check("R1 ready delay", cyc, 32'd19);
        @(negedge clk); look_vld = 0;
        @(posedge clk); #2;
        check("R1 lookup during init ignored", {31'd0, res_vld_o}, 32'd0);

        // R2: start state of every context
        for (int c = 0; c < NUM_CTX; c++) step(1, c, 0, 0, 0, "R2");
        step(1, 25, 1, 0, 0, "");
        idle();
        #2;
        check("R11 out-of-range lookup ignored", {15'd0, res_vld_o, qe_o}, {15'd0, 1'b1, 16'h5601});

        // R5 / R8 / R6 / R7 directed sequence
        step(1, 5, 0, 1, 1, "R5");
        step(1, 5, 0, 1, 1, "R8 forward after MPS renorm");
        step(1, 5, 1, 1, 1, "R8 second forward");
        step(1, 7, 0, 1, 1, "R5 LPS renorm");
        step(1, 5, 0, 1, 0, "R5 next-on-LPS");
        step(1, 7, 1, 1, 0, "R7 no renorm keeps index");
        step(1, 7, 1, 1, 1, "R6 switch on LPS");
        step(1, 7, 0, 1, 0, "R6 flipped MPS");
        step(1, 9, 1, 1, 0, "R6 no switch in state 1");
        step(0, 0, 0, 1, 1, "");
        idle();
        #2;
        check("R10 update retires result", {31'd0, res_vld_o}, 32'd0);
        step(0, 0, 0, 1, 1, "");
        step(1, 9, 1, 0, 0, "R7 update without result ignored");
        step(1, 0, 0, 0, 0, "R9 untouched context");
        step(1, 17, 0, 0, 0, "R9 untouched context");

        // R5: mixed traffic
        lf = 32'h1234_5678;
        for (int i = 0; i < 600; i++) begin
            int c;
            lf = lf * 1103515245 + 12345;
            c = int'((lf >> 16) % 21);
            if (c >= NUM_CTX) c = 25;
            step(lf[9] | lf[10], c, lf[11], lf[12] | lf[13], lf[14] | lf[15], "R5 mixed");
        end
        idle();
        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule